// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block runs external program-memory and data-memory cycles for a small 8-bit controller. The core hands it an address, write data, a write flag and a memory-space flag through a valid/ready request port. The block then steps the external pins through a fixed sequence:

1. A setup clock.
2. An address-strobe pulse, with the low address byte on a shared address/data port.
3. An address hold clock.
4. A turnaround clock.
5. A data-strobe pulse, during which write data is driven or read data is sampled.

The cycle closes with a one-clock done pulse that carries the read byte.

The upper address byte leaves on a separate port, one enable bit per nibble. A nibble that is not carrying address keeps its general-purpose output value and enable. An extended-timing flag, taken with each request, stretches the data-strobe phase by two clocks. A bus-float input releases the shared port, the upper port and the strobe/write lines, so that another master can use the bus.

Every pin that can float is given as a value output plus an output-enable. The pad ring builds the tri-state drivers from these pairs.

Top module: `xmem_bus_ctl`

## Requirements
- R1: While reset is held, these outputs are as follows:
  - `asN`, `dsN`, `rwN` and `dmN` are 1.
  - `adOe`, `rspDone` and all bits of `hiOe` are 0.
  - `reqReady` is 1 once reset is released and `busFloat` is 0.
- R2: A request is accepted at the rising edge where `reqValid` and `reqReady` are both 1; call that edge clock 0.
  - Clock 1 is a setup clock with `asN` high.
  - `asN` is then low for ADDR_CLKS clocks (default 1, so clock 2 only), then high again.
  - From clock 1 through the clock after `asN` rises, `adOut` carries address bits 7..0 with `adOe`=1.
- R3: `dsN` goes low one turnaround clock after the address hold clock, and stays low for STRB_CLKS clocks (default 2). `dsN` is never low while `asN` is low.
- R4: On a read (`reqWrite`=0), `adOe` is 0 from the turnaround clock to the end of the cycle. The value on `adIn` in the last `dsN`-low clock is returned on `rspData` while `rspDone` is 1.
- R5: On a write (`reqWrite`=1):
  - `adOut` carries the write byte with `adOe`=1 from the turnaround clock through the done clock, so the byte is stable before `dsN` falls.
  - `rwN` is 0 from the setup clock through the done clock. It is 1 on reads.
- R6: `dmN` is 0 from the setup clock through the done clock when `reqData`=1, and 1 for program-memory accesses. It does not change while `asN` is low.
- R7: `hiNibAddr` selects the source of each nibble of the upper port, and `hiOut`/`hiOe` follow one clock after their inputs.
  - Bit 0 set: `hiOut[3:0]` carries address bits 11..8 with `hiOe[3:0]`=4'hF.
  - Bit 1 set: `hiOut[7:4]` carries address bits 15..12 with `hiOe[7:4]`=4'hF.
  - A clear bit passes the matching nibble of `gpioOut` and `gpioOe` instead.
- R8: `extTiming`=1 with a request lengthens the `dsN`-low phase by exactly two clocks and moves the done pulse two clocks later.
- R9: While `busFloat` is 1:
  - `adOe` and `strobeOe` are 0 in the same clock.
  - `hiOe` is 8'h00 from the next clock.
  - `reqReady` is 0 and no request is accepted.
- R10: `rspDone` is high for exactly one clock.
  - With default parameters it is high in clock 7 after acceptance, or clock 9 with extended timing.
  - `reqReady` is 0 from acceptance until the clock after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; all timing in whole periods |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Core request valid |
| reqReady | output | 1 | Idle and not floated; request accepted when both high |
| reqAddr | input | 16 | Request address |
| reqWdata | input | 8 | Write byte |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqData | input | 1 | 1 = data-memory space, 0 = program space |
| extTiming | input | 1 | Stretch this cycle by two clocks |
| busFloat | input | 1 | Release bus pins for another master |
| hiNibAddr | input | 2 | Per-nibble address enable for the upper port |
| gpioOut | input | 8 | Upper-port values for non-address nibbles |
| gpioOe | input | 8 | Upper-port enables for non-address nibbles |
| rspData | output | 8 | Read byte, valid with rspDone |
| rspDone | output | 1 | One-clock end-of-cycle pulse |
| adOut | output | 8 | Shared address/data port value |
| adOe | output | 1 | Shared port drive enable |
| adIn | input | 8 | Shared port pad input |
| hiOut | output | 8 | Upper port value |
| hiOe | output | 8 | Upper port per-bit drive enable |
| asN | output | 1 | Address strobe, active low |
| dsN | output | 1 | Data strobe, active low |
| rwN | output | 1 | Low during writes |
| strobeOe | output | 1 | Drive enable for asN, dsN, rwN |
| dmN | output | 1 | Data-memory select, active low |

## Verification
The properties assume the following about the inputs:
- `hiNibAddr`, `gpioOut` and `gpioOe` change only at clock edges.
- `busFloat` is either held over several clocks or raised while the sequencer is idle, so the float property sees the register that it gates settle one clock later.

The bench keeps to these assumptions:
- It changes every input on the falling clock edge.
- It raises `busFloat` only between transactions.
- It holds `adIn` constant across a whole read, so the sampled byte does not depend on which strobe-low clock captures it.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ADDR,
    ST_HOLD,
    ST_GAP,
    ST_STRB,
    ST_DONE
  } xmemState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;    // latch the request this edge
    logic busy;       // a cycle is in progress (setup..done)
    logic asLow;      // address strobe asserted
    logic dsLow;      // data strobe asserted
    logic driveAddr;  // shared port carries low address
    logic driveData;  // shared port may carry write data
    logic sampleRd;   // capture pad input at this edge
    logic done;       // end-of-cycle pulse
  } xmemCtl_t;

endpackage

// File: rtl/xmem_ctrl.sv
module xmem_ctrl
  import xmem_pkg::*;
#(
  parameter int ADDR_CLKS = 1,
  parameter int STRB_CLKS = 2,
  parameter int EXT_CLKS  = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     extTiming,
  input  logic     busFloat,
  output logic     reqReady,
  output xmemCtl_t ctl
);

  localparam int MAXC  = (STRB_CLKS + EXT_CLKS > ADDR_CLKS) ? STRB_CLKS + EXT_CLKS : ADDR_CLKS;
  localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;

  xmemState_t       state;
  logic [CNT_W-1:0] cnt;
  logic             extQ;
  logic             accept;

  assign accept = (state == ST_IDLE) && reqValid && !busFloat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      extQ  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state <= ST_SETUP;
            extQ  <= extTiming;
          end
        end
        ST_SETUP: begin
          state <= ST_ADDR;
          cnt   <= CNT_W'(ADDR_CLKS - 1);
        end
        ST_ADDR: begin
          if (cnt == '0) state <= ST_HOLD;
          else           cnt   <= cnt - 1'b1;
        end
        ST_HOLD: state <= ST_GAP;
        ST_GAP: begin
          state <= ST_STRB;
          cnt   <= extQ ? CNT_W'(STRB_CLKS + EXT_CLKS - 1) : CNT_W'(STRB_CLKS - 1);
        end
        ST_STRB: begin
          if (cnt == '0) state <= ST_DONE;
          else           cnt   <= cnt - 1'b1;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl           = '0;
    ctl.capture   = accept;
    ctl.busy      = (state != ST_IDLE);
    ctl.asLow     = (state == ST_ADDR);
    ctl.dsLow     = (state == ST_STRB);
    ctl.driveAddr = (state == ST_SETUP) || (state == ST_ADDR) || (state == ST_HOLD);
    ctl.driveData = (state == ST_GAP) || (state == ST_STRB) || (state == ST_DONE);
    ctl.sampleRd  = (state == ST_STRB) && (cnt == '0);
    ctl.done      = (state == ST_DONE);
  end

  assign reqReady = (state == ST_IDLE) && !busFloat;

endmodule

// File: rtl/xmem_dpath.sv
module xmem_dpath
  import xmem_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  xmemCtl_t                 ctl,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [DATA_W-1:0]        reqWdata,
  input  logic                     reqWrite,
  input  logic                     reqData,
  input  logic                     busFloat,
  input  logic [(ADDR_W-DATA_W)/4-1:0] hiNibAddr,
  input  logic [ADDR_W-DATA_W-1:0] gpioOut,
  input  logic [ADDR_W-DATA_W-1:0] gpioOe,
  input  logic [DATA_W-1:0]        adIn,
  output logic [DATA_W-1:0]        rspData,
  output logic                     rspDone,
  output logic [DATA_W-1:0]        adOut,
  output logic                     adOe,
  output logic [ADDR_W-DATA_W-1:0] hiOut,
  output logic [ADDR_W-DATA_W-1:0] hiOe,
  output logic                     asN,
  output logic                     dsN,
  output logic                     rwN,
  output logic                     strobeOe,
  output logic                     dmN
);

  localparam int HI_W   = ADDR_W - DATA_W;
  localparam int NIB_W  = 4;
  localparam int NUM_NIB = HI_W / NIB_W;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic              wrQ;
  logic              dmQ;
  logic [DATA_W-1:0] rdQ;
  logic [HI_W-1:0]   hiOutD, hiOeD, hiOutQ, hiOeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      wrQ    <= 1'b0;
      dmQ    <= 1'b0;
      rdQ    <= '0;
    end else begin
      if (ctl.capture) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
        wrQ    <= reqWrite;
        dmQ    <= reqData;
      end
      if (ctl.sampleRd) rdQ <= adIn;
    end
  end

  // per-nibble source select for the upper port
  for (genvar n = 0; n < NUM_NIB; n++) begin : g_nib
    localparam int LO = n * NIB_W;
    always_comb begin
      if (hiNibAddr[n]) begin
        hiOutD[LO +: NIB_W] = ctl.capture ? reqAddr[DATA_W + LO +: NIB_W]
                                          : addrQ[DATA_W + LO +: NIB_W];
        hiOeD[LO +: NIB_W]  = busFloat ? '0 : '1;
      end else begin
        hiOutD[LO +: NIB_W] = gpioOut[LO +: NIB_W];
        hiOeD[LO +: NIB_W]  = busFloat ? '0 : gpioOe[LO +: NIB_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiOutQ <= '0;
      hiOeQ  <= '0;
    end else begin
      hiOutQ <= hiOutD;
      hiOeQ  <= hiOeD;
    end
  end

  assign hiOut    = hiOutQ;
  assign hiOe     = hiOeQ;
  assign adOut    = ctl.driveAddr ? addrQ[DATA_W-1:0] : wdataQ;
  assign adOe     = !busFloat && (ctl.driveAddr || (ctl.driveData && wrQ));
  assign asN      = !ctl.asLow;
  assign dsN      = !ctl.dsLow;
  assign rwN      = !(ctl.busy && wrQ);
  assign dmN      = !(ctl.busy && dmQ);
  assign strobeOe = !busFloat;
  assign rspData  = rdQ;
  assign rspDone  = ctl.done;

endmodule

// File: rtl/xmem_bus_ctl.sv
module xmem_bus_ctl
  import xmem_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int ADDR_CLKS = 1,
  parameter int STRB_CLKS = 2,
  parameter int EXT_CLKS  = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         reqValid,
  output logic                         reqReady,
  input  logic [ADDR_W-1:0]            reqAddr,
  input  logic [DATA_W-1:0]            reqWdata,
  input  logic                         reqWrite,
  input  logic                         reqData,
  input  logic                         extTiming,
  input  logic                         busFloat,
  input  logic [(ADDR_W-DATA_W)/4-1:0] hiNibAddr,
  input  logic [ADDR_W-DATA_W-1:0]     gpioOut,
  input  logic [ADDR_W-DATA_W-1:0]     gpioOe,
  output logic [DATA_W-1:0]            rspData,
  output logic                         rspDone,
  output logic [DATA_W-1:0]            adOut,
  output logic                         adOe,
  input  logic [DATA_W-1:0]            adIn,
  output logic [ADDR_W-DATA_W-1:0]     hiOut,
  output logic [ADDR_W-DATA_W-1:0]     hiOe,
  output logic                         asN,
  output logic                         dsN,
  output logic                         rwN,
  output logic                         strobeOe,
  output logic                         dmN
);

  xmemCtl_t ctl;

  xmem_ctrl #(
    .ADDR_CLKS(ADDR_CLKS),
    .STRB_CLKS(STRB_CLKS),
    .EXT_CLKS (EXT_CLKS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .extTiming(extTiming),
    .busFloat (busFloat),
    .reqReady (reqReady),
    .ctl      (ctl)
  );

  xmem_dpath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .reqWrite (reqWrite),
    .reqData  (reqData),
    .busFloat (busFloat),
    .hiNibAddr(hiNibAddr),
    .gpioOut  (gpioOut),
    .gpioOe   (gpioOe),
    .adIn     (adIn),
    .rspData  (rspData),
    .rspDone  (rspDone),
    .adOut    (adOut),
    .adOe     (adOe),
    .hiOut    (hiOut),
    .hiOe     (hiOe),
    .asN      (asN),
    .dsN      (dsN),
    .rwN      (rwN),
    .strobeOe (strobeOe),
    .dmN      (dmN)
  );

endmodule

// File: rtl/xmem_chk.sv
module xmem_chk #(
  parameter int DATA_W = 8,
  parameter int HI_W   = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busFloat,
  input logic              reqValid,
  input logic              reqReady,
  input logic              asN,
  input logic              dsN,
  input logic              rwN,
  input logic              dmN,
  input logic              adOe,
  input logic [DATA_W-1:0] adOut,
  input logic              strobeOe,
  input logic [HI_W-1:0]   hiOe,
  input logic              rspDone
);

  a_r2_addr_at_as_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(asN) && !busFloat |-> adOe && dsN);

  a_r3_ds_not_with_as: assert property (@(posedge clk) disable iff (!rstN)
    !dsN |-> asN);

  a_r4_read_released: assert property (@(posedge clk) disable iff (!rstN)
    !dsN && rwN |-> !adOe);

  a_r5_rw_steady: assert property (@(posedge clk) disable iff (!rstN)
    !dsN |-> $stable(rwN));

  a_r6_dm_steady: assert property (@(posedge clk) disable iff (!rstN)
    !asN |-> $stable(dmN));

  a_r9_float_now: assert property (@(posedge clk) disable iff (!rstN)
    busFloat |-> !adOe && !strobeOe && !reqReady);

  a_r9_float_hi: assert property (@(posedge clk) disable iff (!rstN)
    busFloat |=> hiOe == '0);

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);

endmodule

bind xmem_bus_ctl xmem_chk #(.DATA_W(DATA_W), .HI_W(ADDR_W-DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .busFloat(busFloat), .reqValid(reqValid),
  .reqReady(reqReady), .asN(asN), .dsN(dsN), .rwN(rwN), .dmN(dmN),
  .adOe(adOe), .adOut(adOut), .strobeOe(strobeOe), .hiOe(hiOe),
  .rspDone(rspDone)
);

// File: tb/xmem_bus_ctl_tb.sv
module xmem_bus_ctl_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [15:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        reqWrite = 1'b0;
  logic        reqData = 1'b0;
  logic        extTiming = 1'b0;
  logic        busFloat = 1'b0;
  logic [1:0]  hiNibAddr = 2'b11;
  logic [7:0]  gpioOut = '0;
  logic [7:0]  gpioOe = '0;
  logic [7:0]  rspData;
  logic        rspDone;
  logic [7:0]  adOut;
  logic        adOe;
  logic [7:0]  adIn = '0;
  logic [7:0]  hiOut;
  logic [7:0]  hiOe;
  logic        asN, dsN, rwN, strobeOe, dmN;

  always #5 clk = ~clk;

  xmem_bus_ctl u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqWrite(reqWrite),
    .reqData(reqData), .extTiming(extTiming), .busFloat(busFloat),
    .hiNibAddr(hiNibAddr), .gpioOut(gpioOut), .gpioOe(gpioOe),
    .rspData(rspData), .rspDone(rspDone), .adOut(adOut), .adOe(adOe),
    .adIn(adIn), .hiOut(hiOut), .hiOe(hiOe), .asN(asN), .dsN(dsN),
    .rwN(rwN), .strobeOe(strobeOe), .dmN(dmN)
  );

  typedef struct packed {
    logic [15:0] addr;
    logic [7:0]  wdata;
    logic [7:0]  rdIn;
    logic        wr;
    logic        dm;
    logic        ext;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VEC [NVEC] = '{
    '{16'h1234, 8'h00, 8'hA5, 1'b0, 1'b0, 1'b0},
    '{16'hABCD, 8'h3C, 8'h00, 1'b1, 1'b1, 1'b0},
    '{16'h00FF, 8'h00, 8'h5A, 1'b0, 1'b1, 1'b1},
    '{16'hFF00, 8'hC3, 8'h00, 1'b1, 1'b0, 1'b1},
    '{16'hFFFF, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0},
    '{16'h0000, 8'hFF, 8'h11, 1'b1, 1'b1, 1'b0}
  };

  int checks = 0;
  int fails  = 0;

  // observations of one transaction
  int         asCnt, dsCnt, doneCnt, doneAt, readyAt, asBadAddr;
  logic [7:0] adAtAs, hiAtAs, hiOeAtAs, adAtDs, rdAtDone;
  logic       adOeAtAs, dmAtAs, rwAtDs, adOeAtDs;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input vec_t v);
    @(negedge clk);
    reqValid  = 1'b1;
    reqAddr   = v.addr;
    reqWdata  = v.wdata;
    reqWrite  = v.wr;
    reqData   = v.dm;
    extTiming = v.ext;
    adIn      = v.rdIn;
    asCnt = 0; dsCnt = 0; doneCnt = 0; doneAt = 0; readyAt = 0;
    @(negedge clk);
    reqValid = 1'b0;
    for (int k = 1; k <= 12; k++) begin
      if (!asN) begin
        asCnt++;
        adAtAs = adOut; adOeAtAs = adOe; dmAtAs = dmN;
        hiAtAs = hiOut; hiOeAtAs = hiOe;
      end
      if (!dsN) begin
        dsCnt++;
        rwAtDs = rwN; adAtDs = adOut; adOeAtDs = adOe;
      end
      if (rspDone) begin
        doneCnt++; doneAt = k; rdAtDone = rspData;
      end
      if (reqReady && readyAt == 0) readyAt = k;
      @(negedge clk);
    end
  endtask

  task automatic check_vec(input vec_t v);
    chk("R2 as pulses", asCnt, 1);
    chk("R2 low address", {adOeAtAs, adAtAs}, {1'b1, v.addr[7:0]});
    if (v.ext) chk("R8 stretched strobe", dsCnt, 4);
    else       chk("R3 strobe width", dsCnt, 2);
    chk("R10 done count", doneCnt, 1);
    chk("R10 done clock", doneAt, v.ext ? 9 : 7);
    chk("R10 ready after done", readyAt, v.ext ? 10 : 8);
    chk("R6 dm select", dmAtAs, !v.dm);
    chk("R5 rw line", rwAtDs, !v.wr);
    if (v.wr) chk("R5 write data", {adOeAtDs, adAtDs}, {1'b1, v.wdata});
    else begin
      chk("R4 port released", adOeAtDs, 1'b0);
      chk("R4 read data", rdAtDone, v.rdIn);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 strobes", {asN, dsN, rwN, dmN}, 4'hF);
    chk("R1 enables", {adOe, rspDone, hiOe}, 10'h000);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 ready", reqReady, 1'b1);

    // table of transactions, both upper nibbles carry address
    for (int i = 0; i < NVEC; i++) begin
      run(VEC[i]);
      check_vec(VEC[i]);
      chk("R7 upper address", {hiOeAtAs, hiAtAs}, {8'hFF, VEC[i].addr[15:8]});
    end

    // R7: no address nibbles, general-purpose values follow one clock later
    @(negedge clk);
    hiNibAddr = 2'b00; gpioOut = 8'h5A; gpioOe = 8'hC3;
    @(negedge clk);
    chk("R7 gpio passthrough", {hiOe, hiOut}, 16'hC35A);

    // R7: low nibble only carries address bits 11..8
    hiNibAddr = 2'b01;
    run('{16'hB72E, 8'h00, 8'h66, 1'b0, 1'b0, 1'b0});
    chk("R7 low nibble address", {hiOeAtAs, hiAtAs}, 16'hCF57);
    chk("R4 read in nibble mode", rdAtDone, 8'h66);

    // R9: bus float
    @(negedge clk);
    busFloat = 1'b1;
    #1;
    chk("R9 immediate release", {adOe, strobeOe, reqReady}, 3'b000);
    @(negedge clk);
    chk("R9 upper released", hiOe, 8'h00);
    reqValid = 1'b1; reqWrite = 1'b1;
    asCnt = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (!asN) asCnt++;
    end
    chk("R9 request ignored", asCnt, 0);
    reqValid = 1'b0;
    busFloat = 1'b0;
    @(negedge clk);
    chk("R9 rw idle after float", {rwN, reqReady, strobeOe}, 3'b111);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule